// File: doc/BRIEF.md
# Memory Test Command Engine

This block is a test function that a host drives through a small word-addressed register port. The host loads a source address, a destination address, a word count, an interrupt kind and an interrupt number, then writes a command word. The engine carries the command out on a memory master port. It can read a buffer and fold it into a checksum, fill a buffer with a known pattern, copy one buffer to another, or simply raise an interrupt. When it finishes, it records the outcome as separate success, failure and bad-address bits in a status word.

Completion of each operation is signalled on one of three interrupt pulse outputs: legacy, MSI or MSI-X. The pulse carries a vector number. A pattern register that reads back whatever was last written lets the host confirm basic register access before it issues any commands. Physical bus layers, real message delivery and configuration space are left to the surrounding system.

Top module: `memtest_engine`

## Requirements
- R1: Register word offsets are pattern 0, command 1, status 2, source 3, destination 4, size 5, checksum 6, interrupt kind 7 and interrupt number 8. The pattern register returns the last value written to it. After reset every register reads zero, no interrupt line is high and `m_req` is low.
- R2: Command bit 3 reads `size` words from the source address upward in steps of 4 and stores the 32-bit XOR of those words in the checksum register. It then sets status bit 0 (read ok).
- R3: Command bit 4 writes word i as FILL_SEED+i to destination+4i. It stores the XOR of the written words as the checksum and sets status bit 2 (write ok). A size of 0 makes no memory access, succeeds and stores a checksum of 0.
- R4: Command bit 5 copies `size` words from the source to the destination. It stores the XOR of the copied words and sets status bit 4 (copy ok).
- R5: An address that is zero or has a nonzero low two bits is invalid. Only the source is checked for a read, only the destination for a write, and both for a copy. An invalid address means no memory access is made. The status then gets the fail bit of the operation (read 1, write 3, copy 5) together with bit 7 for a bad source and/or bit 8 for a bad destination.
- R6: Every read, write or copy ends with one interrupt of the kind held in the kind register (0 legacy, 1 MSI, 2 MSI-X). The interrupt is a one-cycle pulse on `irq_legacy`, `irq_msi` or `irq_msix`, with `irq_vec` equal to the interrupt number, and it sets status bit 6.
- R7: The interrupt number must be 0 for legacy, 1..32 for MSI and 1..2048 for MSI-X, and kind 3 is never valid. An out-of-range number produces no pulse and leaves status bit 6 clear.
- R8: Command bits 0, 1 and 2 raise a legacy, MSI or MSI-X interrupt respectively, regardless of the kind register. They use the interrupt number register and set only status bit 6.
- R9: When several command bits are written together, only the lowest-numbered one is executed.
- R10: While an operation runs, the command register reads back the single executing bit, and it clears itself when the operation completes. A command written while one is running is ignored.
- R11: Starting a command clears the status word, so it reports only the latest operation.
- R12: An error response on `m_ack` ends the operation with its fail bit set and leaves the checksum unchanged. `m_req` with its address and direction stays steady until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_sel | input | 1 | Register access strobe |
| s_we | input | 1 | Register write when high, read when low |
| s_addr | input | 4 | Register word offset |
| s_wdata | input | DW | Register write data |
| s_rdata | output | DW | Register read data (combinational from s_addr) |
| m_req | output | 1 | Memory request, held until acknowledged |
| m_we | output | 1 | Memory write when high |
| m_addr | output | AW | Memory byte address |
| m_wdata | output | DW | Memory write data |
| m_ack | input | 1 | Memory acknowledge, one cycle |
| m_err | input | 1 | Error response qualifying m_ack |
| m_rdata | input | DW | Memory read data, valid with m_ack |
| irq_legacy | output | 1 | Legacy interrupt pulse |
| irq_msi | output | 1 | MSI interrupt pulse |
| irq_msix | output | 1 | MSI-X interrupt pulse |
| irq_vec | output | VEC_W | Vector number accompanying a pulse |

## Verification
The bench builds the engine with an 8-bit size register. This makes a maximum-length read of 255 words a short run, so the last-index compare and checksum fold are exercised at the top of the count. The MSI and MSI-X limits keep their defaults of 32 and 2048. Both boundary values (2048 accepted, 33 and 0 rejected) are therefore reachable. A non-trivial FILL_SEED makes the write pattern and its checksum distinguishable from the default memory contents. The memory model varies its acknowledge latency between zero and two wait cycles.

// File: rtl/memtest_pkg.sv
// Shared constants and types of the memory test command engine.
// Assumes 32-bit data words and word-granular register offsets.
package memtest_pkg;

    localparam int RA_W  = 4;
    localparam int CMD_W = 6;
    localparam int ST_W  = 9;

    localparam logic [RA_W-1:0] RA_PATTERN = 4'd0;
    localparam logic [RA_W-1:0] RA_CMD     = 4'd1;
    localparam logic [RA_W-1:0] RA_STATUS  = 4'd2;
    localparam logic [RA_W-1:0] RA_SRC     = 4'd3;
    localparam logic [RA_W-1:0] RA_DST     = 4'd4;
    localparam logic [RA_W-1:0] RA_SIZE    = 4'd5;
    localparam logic [RA_W-1:0] RA_CSUM    = 4'd6;
    localparam logic [RA_W-1:0] RA_IKIND   = 4'd7;
    localparam logic [RA_W-1:0] RA_INUM    = 4'd8;

    localparam int CB_LEG  = 0;
    localparam int CB_MSI  = 1;
    localparam int CB_MSIX = 2;
    localparam int CB_RD   = 3;
    localparam int CB_WR   = 4;
    localparam int CB_CP   = 5;

    localparam int SB_RD_OK   = 0;
    localparam int SB_RD_FAIL = 1;
    localparam int SB_WR_OK   = 2;
    localparam int SB_WR_FAIL = 3;
    localparam int SB_CP_OK   = 4;
    localparam int SB_CP_FAIL = 5;
    localparam int SB_IRQ     = 6;
    localparam int SB_BAD_SRC = 7;
    localparam int SB_BAD_DST = 8;

    typedef enum logic [1:0] {
        IK_LEGACY = 2'd0,
        IK_MSI    = 2'd1,
        IK_MSIX   = 2'd2,
        IK_NONE   = 2'd3
    } irq_kind_e;

    typedef enum logic [1:0] {
        ES_IDLE = 2'd0,
        ES_RD   = 2'd1,
        ES_WR   = 2'd2,
        ES_FIN  = 2'd3
    } eng_state_e;

endpackage

// File: rtl/memtest_regs.sv
// Register file of the test engine: host-visible registers, command
// acceptance with lowest-bit priority, and status accumulation.
// Assumes done pulses only while a command is held (busy).
module memtest_regs
    import memtest_pkg::*;
#(
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_sel,
    input  logic              s_we,
    input  logic [RA_W-1:0]   s_addr,
    input  logic [DW-1:0]     s_wdata,
    output logic [DW-1:0]     s_rdata,
    input  logic              done,
    input  logic [ST_W-1:0]   done_status,
    input  logic              irq_raised,
    input  logic              csum_we,
    input  logic [DW-1:0]     csum_val,
    output logic              start,
    output logic [CMD_W-1:0]  start_cmd,
    output logic              busy,
    output logic [AW-1:0]     src,
    output logic [AW-1:0]     dst,
    output logic [SIZE_W-1:0] size,
    output logic [1:0]        ikind,
    output logic [DW-1:0]     inum
);

    logic [DW-1:0]    pattern_q;
    logic [CMD_W-1:0] cmd_q;
    logic [ST_W-1:0]  status_q;
    logic [DW-1:0]    csum_q;
    logic [ST_W-1:0]  raised_bit;
    logic             wr_hit;
    logic [CMD_W-1:0] cmd_in;

    // Decode a host write and isolate the lowest set command bit.
    always_comb begin
        wr_hit    = s_sel && s_we;
        cmd_in    = s_wdata[CMD_W-1:0];
        start_cmd = cmd_in & (~cmd_in + CMD_W'(1));
        start     = wr_hit && (s_addr == RA_CMD) && (cmd_q == '0) && (cmd_in != '0);
        busy      = (cmd_q != '0);
        raised_bit = '0;
        raised_bit[SB_IRQ] = irq_raised;
    end

    // Plain configuration registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pattern_q <= '0;
            src       <= '0;
            dst       <= '0;
            size      <= '0;
            ikind     <= '0;
            inum      <= '0;
        end else if (wr_hit) begin
            case (s_addr)
                RA_PATTERN: pattern_q <= s_wdata;
                RA_SRC:     src       <= s_wdata[AW-1:0];
                RA_DST:     dst       <= s_wdata[AW-1:0];
                RA_SIZE:    size      <= s_wdata[SIZE_W-1:0];
                RA_IKIND:   ikind     <= s_wdata[1:0];
                RA_INUM:    inum      <= s_wdata;
                default:    ;
            endcase
        end
    end

    // Command holding register: set on accept, cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q <= start_cmd;
        end else if (done) begin
            cmd_q <= '0;
        end
    end

    // Status word: cleared at start, accumulates the outcome at done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (start) begin
            status_q <= '0;
        end else if (done) begin
            status_q <= status_q | done_status | raised_bit;
        end
    end

    // Checksum result of the last successful data operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csum_q <= '0;
        end else if (csum_we) begin
            csum_q <= csum_val;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (s_addr)
            RA_PATTERN: s_rdata = pattern_q;
            RA_CMD:     s_rdata = DW'(cmd_q);
            RA_STATUS:  s_rdata = DW'(status_q);
            RA_SRC:     s_rdata = DW'(src);
            RA_DST:     s_rdata = DW'(dst);
            RA_SIZE:    s_rdata = DW'(size);
            RA_CSUM:    s_rdata = csum_q;
            RA_IKIND:   s_rdata = DW'(ikind);
            RA_INUM:    s_rdata = inum;
            default:    s_rdata = '0;
        endcase
    end

endmodule

// File: rtl/memtest_ctrl.sv
// Operation sequencer: validates addresses, walks the buffers on the
// memory master port, folds the checksum and reports the outcome.
// Assumes one outstanding request; m_ack arrives for the held request.
module memtest_ctrl
    import memtest_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          SIZE_W    = 16,
    parameter logic [31:0] FILL_SEED = 32'hC0DE_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CMD_W-1:0]  start_cmd,
    input  logic [AW-1:0]     src,
    input  logic [AW-1:0]     dst,
    input  logic [SIZE_W-1:0] size,
    input  logic [1:0]        ikind,
    input  logic [DW-1:0]     inum,
    output logic              m_req,
    output logic              m_we,
    output logic [AW-1:0]     m_addr,
    output logic [DW-1:0]     m_wdata,
    input  logic              m_ack,
    input  logic              m_err,
    input  logic [DW-1:0]     m_rdata,
    output logic              done,
    output logic [ST_W-1:0]   done_status,
    output logic              csum_we,
    output logic [DW-1:0]     csum_val,
    output logic              fire,
    output logic [1:0]        fire_kind,
    output logic [DW-1:0]     fire_num
);

    localparam int STEP = DW / 8;

    eng_state_e       state_q;
    logic [CMD_W-1:0] op_q;
    logic [AW-1:0]    src_q, dst_q;
    logic [SIZE_W-1:0] size_q, idx_q;
    logic [1:0]       ikind_q;
    logic [DW-1:0]    inum_q, csum_q, data_q;
    logic             ok_q, bad_src_q, bad_dst_q;
    logic             need_src, need_dst, bad_src_in, bad_dst_in, is_irq_in;
    logic             last;

    // Address validation of the incoming command.
    always_comb begin
        need_src   = start_cmd[CB_RD] | start_cmd[CB_CP];
        need_dst   = start_cmd[CB_WR] | start_cmd[CB_CP];
        bad_src_in = need_src && ((src == '0) || (src[1:0] != 2'b00));
        bad_dst_in = need_dst && ((dst == '0) || (dst[1:0] != 2'b00));
        is_irq_in  = |start_cmd[CB_MSIX:CB_LEG];
        last       = (idx_q == size_q - SIZE_W'(1));
    end

    // Sequencer state, buffer pointers and checksum fold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ES_IDLE;
            op_q      <= '0;
            src_q     <= '0;
            dst_q     <= '0;
            size_q    <= '0;
            idx_q     <= '0;
            ikind_q   <= '0;
            inum_q    <= '0;
            csum_q    <= '0;
            data_q    <= '0;
            ok_q      <= 1'b0;
            bad_src_q <= 1'b0;
            bad_dst_q <= 1'b0;
        end else begin
            case (state_q)
                ES_IDLE: begin
                    if (start) begin
                        op_q      <= start_cmd;
                        src_q     <= src;
                        dst_q     <= dst;
                        size_q    <= size;
                        ikind_q   <= ikind;
                        inum_q    <= inum;
                        idx_q     <= '0;
                        csum_q    <= '0;
                        bad_src_q <= bad_src_in;
                        bad_dst_q <= bad_dst_in;
                        ok_q      <= !(bad_src_in || bad_dst_in);
                        if (is_irq_in || bad_src_in || bad_dst_in || (size == '0)) begin
                            state_q <= ES_FIN;
                        end else if (need_src) begin
                            state_q <= ES_RD;
                        end else begin
                            state_q <= ES_WR;
                        end
                    end
                end
                ES_RD: begin
                    if (m_ack) begin
                        if (m_err) begin
                            ok_q    <= 1'b0;
                            state_q <= ES_FIN;
                        end else begin
                            csum_q <= csum_q ^ m_rdata;
                            data_q <= m_rdata;
                            if (op_q[CB_CP]) begin
                                state_q <= ES_WR;
                            end else begin
                                idx_q <= idx_q + SIZE_W'(1);
                                src_q <= src_q + AW'(STEP);
                                if (last) state_q <= ES_FIN;
                            end
                        end
                    end
                end
                ES_WR: begin
                    if (m_ack) begin
                        if (m_err) begin
                            ok_q    <= 1'b0;
                            state_q <= ES_FIN;
                        end else begin
                            if (op_q[CB_WR]) csum_q <= csum_q ^ m_wdata;
                            idx_q <= idx_q + SIZE_W'(1);
                            src_q <= src_q + AW'(STEP);
                            dst_q <= dst_q + AW'(STEP);
                            if (last) begin
                                state_q <= ES_FIN;
                            end else if (op_q[CB_CP]) begin
                                state_q <= ES_RD;
                            end
                        end
                    end
                end
                default: state_q <= ES_IDLE;
            endcase
        end
    end

    // Master port drive.
    always_comb begin
        m_req   = (state_q == ES_RD) || (state_q == ES_WR);
        m_we    = (state_q == ES_WR);
        m_addr  = (state_q == ES_RD) ? src_q : dst_q;
        m_wdata = op_q[CB_CP] ? data_q : (FILL_SEED + DW'(idx_q));
    end

    // Completion report and interrupt request.
    always_comb begin
        done        = (state_q == ES_FIN);
        done_status = '0;
        done_status[SB_RD_OK]   = op_q[CB_RD] &&  ok_q;
        done_status[SB_RD_FAIL] = op_q[CB_RD] && !ok_q;
        done_status[SB_WR_OK]   = op_q[CB_WR] &&  ok_q;
        done_status[SB_WR_FAIL] = op_q[CB_WR] && !ok_q;
        done_status[SB_CP_OK]   = op_q[CB_CP] &&  ok_q;
        done_status[SB_CP_FAIL] = op_q[CB_CP] && !ok_q;
        done_status[SB_BAD_SRC] = bad_src_q;
        done_status[SB_BAD_DST] = bad_dst_q;
        csum_we  = done && ok_q && (|op_q[CB_CP:CB_RD]);
        csum_val = csum_q;
        fire     = done;
        fire_num = inum_q;
        if (op_q[CB_LEG])       fire_kind = IK_LEGACY;
        else if (op_q[CB_MSI])  fire_kind = IK_MSI;
        else if (op_q[CB_MSIX]) fire_kind = IK_MSIX;
        else                    fire_kind = ikind_q;
    end

endmodule

// File: rtl/memtest_irq.sv
// Interrupt stage: checks the vector number against the selected kind
// and emits a one-cycle registered pulse on the matching line.
// Assumes fire is a single-cycle request.
module memtest_irq
    import memtest_pkg::*;
#(
    parameter int DW       = 32,
    parameter int MSI_MAX  = 32,
    parameter int MSIX_MAX = 2048,
    parameter int VEC_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [1:0]       fire_kind,
    input  logic [DW-1:0]    fire_num,
    output logic             raised,
    output logic             irq_legacy,
    output logic             irq_msi,
    output logic             irq_msix,
    output logic [VEC_W-1:0] irq_vec
);

    logic num_ok;

    // Range check of the vector number per interrupt kind.
    always_comb begin
        case (fire_kind)
            IK_LEGACY: num_ok = (fire_num == '0);
            IK_MSI:    num_ok = (fire_num >= DW'(1)) && (fire_num <= DW'(MSI_MAX));
            IK_MSIX:   num_ok = (fire_num >= DW'(1)) && (fire_num <= DW'(MSIX_MAX));
            default:   num_ok = 1'b0;
        endcase
        raised = fire && num_ok;
    end

    // Registered pulse and vector output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_legacy <= 1'b0;
            irq_msi    <= 1'b0;
            irq_msix   <= 1'b0;
            irq_vec    <= '0;
        end else begin
            irq_legacy <= raised && (fire_kind == IK_LEGACY);
            irq_msi    <= raised && (fire_kind == IK_MSI);
            irq_msix   <= raised && (fire_kind == IK_MSIX);
            irq_vec    <= raised ? fire_num[VEC_W-1:0] : '0;
        end
    end

endmodule

// File: rtl/memtest_engine.sv
// Top of the memory test command engine: register port, sequencer and
// interrupt stage. Assumes a single-outstanding memory slave.
module memtest_engine
    import memtest_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter int          SIZE_W    = 16,
    parameter int          MSI_MAX   = 32,
    parameter int          MSIX_MAX  = 2048,
    parameter logic [31:0] FILL_SEED = 32'hC0DE_0000,
    localparam int         VEC_W     = $clog2(MSIX_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_sel,
    input  logic             s_we,
    input  logic [3:0]       s_addr,
    input  logic [DW-1:0]    s_wdata,
    output logic [DW-1:0]    s_rdata,
    output logic             m_req,
    output logic             m_we,
    output logic [AW-1:0]    m_addr,
    output logic [DW-1:0]    m_wdata,
    input  logic             m_ack,
    input  logic             m_err,
    input  logic [DW-1:0]    m_rdata,
    output logic             irq_legacy,
    output logic             irq_msi,
    output logic             irq_msix,
    output logic [VEC_W-1:0] irq_vec
);

    logic              start_w, busy_w, done_w, csum_we_w, fire_w, raised_w;
    logic [CMD_W-1:0]  start_cmd_w;
    logic [AW-1:0]     src_w, dst_w;
    logic [SIZE_W-1:0] size_w;
    logic [1:0]        ikind_w, fire_kind_w;
    logic [DW-1:0]     inum_w, csum_w, fire_num_w;
    logic [ST_W-1:0]   done_status_w;

    memtest_regs #(.AW(AW), .DW(DW), .SIZE_W(SIZE_W)) i_regs (
        .clk(clk), .rst_n(rst_n),
        .s_sel(s_sel), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .done(done_w), .done_status(done_status_w), .irq_raised(raised_w),
        .csum_we(csum_we_w), .csum_val(csum_w),
        .start(start_w), .start_cmd(start_cmd_w), .busy(busy_w),
        .src(src_w), .dst(dst_w), .size(size_w), .ikind(ikind_w), .inum(inum_w)
    );

    memtest_ctrl #(.AW(AW), .DW(DW), .SIZE_W(SIZE_W), .FILL_SEED(FILL_SEED)) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start(start_w), .start_cmd(start_cmd_w),
        .src(src_w), .dst(dst_w), .size(size_w), .ikind(ikind_w), .inum(inum_w),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
        .done(done_w), .done_status(done_status_w),
        .csum_we(csum_we_w), .csum_val(csum_w),
        .fire(fire_w), .fire_kind(fire_kind_w), .fire_num(fire_num_w)
    );

    memtest_irq #(.DW(DW), .MSI_MAX(MSI_MAX), .MSIX_MAX(MSIX_MAX), .VEC_W(VEC_W)) i_irq (
        .clk(clk), .rst_n(rst_n),
        .fire(fire_w), .fire_kind(fire_kind_w), .fire_num(fire_num_w),
        .raised(raised_w),
        .irq_legacy(irq_legacy), .irq_msi(irq_msi), .irq_msix(irq_msix), .irq_vec(irq_vec)
    );

endmodule

// File: rtl/memtest_engine_chk.sv
// Protocol checker for the memory test command engine, bound to the top.
module memtest_engine_chk #(
    parameter int AW      = 32,
    parameter int VEC_W   = 12,
    parameter int MSI_MAX = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_legacy,
    input logic             irq_msi,
    input logic             irq_msix,
    input logic [VEC_W-1:0] irq_vec,
    input logic             m_req,
    input logic             m_we,
    input logic             m_ack,
    input logic [AW-1:0]    m_addr,
    input logic             busy
);

    logic irq_any;
    assign irq_any = irq_legacy | irq_msi | irq_msix;

    // R6: at most one interrupt line at a time
    p_one_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_legacy, irq_msi, irq_msix}));

    // R6: interrupts are single-cycle pulses
    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any |=> !irq_any);

    // R6: legacy carries vector zero
    p_leg_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_legacy |-> (irq_vec == '0));

    // R7: MSI vector inside its legal range
    p_msi_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msi |-> ((irq_vec >= VEC_W'(1)) && (irq_vec <= VEC_W'(MSI_MAX))));

    // R12: request held steady until acknowledged
    p_req_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we)));

    // R10: no memory traffic without a held command
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !m_req);

endmodule

bind memtest_engine memtest_engine_chk #(.AW(AW), .VEC_W(VEC_W), .MSI_MAX(MSI_MAX)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .irq_legacy(irq_legacy), .irq_msi(irq_msi), .irq_msix(irq_msix), .irq_vec(irq_vec),
    .m_req(m_req), .m_we(m_we), .m_ack(m_ack), .m_addr(m_addr), .busy(busy_w)
);

// File: tb/test_memtest_engine.sv
module test_memtest_engine;
    import memtest_pkg::*;

    localparam logic [31:0] SEED = 32'hBEEF_0000;
    localparam int VW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_sel = 1'b0, s_we = 1'b0;
    logic [3:0] s_addr = '0;
    logic [31:0] s_wdata = '0, s_rdata;
    logic m_req, m_we;
    logic [31:0] m_addr, m_wdata;
    logic m_ack = 1'b0, m_err = 1'b0;
    logic [31:0] m_rdata = '0;
    logic irq_legacy, irq_msi, irq_msix;
    logic [VW-1:0] irq_vec;

    always #5 clk = ~clk;

    memtest_engine #(.SIZE_W(8), .FILL_SEED(SEED)) i_memtest_engine (
        .clk(clk), .rst_n(rst_n),
        .s_sel(s_sel), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
        .irq_legacy(irq_legacy), .irq_msi(irq_msi), .irq_msix(irq_msix), .irq_vec(irq_vec)
    );

    int total = 0, bad = 0;
    logic [31:0] mem [logic [31:0]];
    logic [31:0] err_addr = 32'hFFFF_FFF0;
    int acc_cnt = 0, wcnt = 0, lat = 0;
    int irq_cnt = 0;
    int last_kind = -1;
    int last_vec = -1;
    bit irq_allow = 1'b0;
    bit in_cmd = 1'b0;

    function automatic logic [31:0] memrd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'h5A5A_1234;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory slave model with varying latency.
    always @(negedge clk) begin
        if (m_ack) begin
            m_ack = 1'b0;
            m_err = 1'b0;
            wcnt = 0;
        end else if (m_req) begin
            if (wcnt >= lat) begin
                acc_cnt++;
                m_ack = 1'b1;
                m_err = (m_addr == err_addr);
                if (m_we) begin
                    if (!m_err) mem[m_addr] = m_wdata;
                end else begin
                    m_rdata = memrd(m_addr);
                end
                wcnt = 0;
                lat = (lat + 1) % 3;
            end else begin
                wcnt++;
            end
        end
    end

    // Per-clock reference comparison of interrupt lines and idle port.
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if ((int'(irq_legacy) + int'(irq_msi) + int'(irq_msix)) > 1) begin
                bad++;
                $display("FAIL R6 lines actual=%b expected=onehot0", {irq_legacy, irq_msi, irq_msix});
            end
            if (irq_legacy || irq_msi || irq_msix) begin
                irq_cnt++;
                last_kind = irq_legacy ? 0 : (irq_msi ? 1 : 2);
                last_vec = int'(irq_vec);
                if (!irq_allow) begin
                    bad++;
                    $display("FAIL R7 unexpected irq actual=1 expected=0");
                end
            end
            if (!in_cmd && m_req) begin
                bad++;
                $display("FAIL R10 m_req actual=1 expected=0");
            end
        end
    end

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        s_sel = 1'b1; s_we = 1'b1; s_addr = a; s_wdata = d;
        @(negedge clk);
        s_sel = 1'b0; s_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        s_sel = 1'b1; s_we = 1'b0; s_addr = a;
        #1 d = s_rdata;
        s_sel = 1'b0;
    endtask

    task automatic setup(input logic [31:0] src, input logic [31:0] dst, input int size,
                         input int kind, input int num);
        reg_wr(RA_SRC, src);
        reg_wr(RA_DST, dst);
        reg_wr(RA_SIZE, size);
        reg_wr(RA_IKIND, kind);
        reg_wr(RA_INUM, num);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int n = 0;
        do begin
            reg_rd(RA_CMD, v);
            n++;
        end while (v != 0 && n < 5000);
        repeat (2) @(negedge clk);
        in_cmd = 1'b0;
    endtask

    task automatic run_cmd(input logic [31:0] cmd, input bit allow);
        irq_cnt = 0; acc_cnt = 0; last_kind = -1; last_vec = -1;
        irq_allow = allow;
        in_cmd = 1'b1;
        reg_wr(RA_CMD, cmd);
        wait_idle();
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [31:0] v, exp_cs, prev_cs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_rd(RA_STATUS, v); chk("R1 reset status", v, 0);
        reg_rd(RA_CMD, v);    chk("R1 reset cmd", v, 0);
        reg_rd(RA_CSUM, v);   chk("R1 reset csum", v, 0);
        reg_rd(RA_PATTERN, v); chk("R1 reset pattern", v, 0);
        chk("R1 reset m_req", {31'b0, m_req}, 0);

        // R1 pattern register
        reg_wr(RA_PATTERN, 32'h1234_5678); reg_rd(RA_PATTERN, v); chk("R1 pattern a", v, 32'h1234_5678);
        reg_wr(RA_PATTERN, 32'hFFFF_0001); reg_rd(RA_PATTERN, v); chk("R1 pattern b", v, 32'hFFFF_0001);

        // R2 read, MSI vector 3
        setup(32'h1000, 32'h2000, 5, 1, 3);
        exp_cs = 0;
        for (int i = 0; i < 5; i++) exp_cs ^= memrd(32'h1000 + 4*i);
        run_cmd(32'h08, 1);
        reg_rd(RA_STATUS, v); chk("R2 status", v, 32'h041);
        reg_rd(RA_CSUM, v);   chk("R2 csum", v, exp_cs);
        chk("R2 accesses", acc_cnt, 5);
        chk("R6 msi count", irq_cnt, 1);
        chk("R6 msi kind", last_kind, 1);
        chk("R6 msi vec", last_vec, 3);

        // R3 write, legacy vector 0
        setup(32'h1000, 32'h2000, 4, 0, 0);
        exp_cs = 0;
        for (int i = 0; i < 4; i++) exp_cs ^= SEED + i;
        run_cmd(32'h10, 1);
        reg_rd(RA_STATUS, v); chk("R3 status", v, 32'h044);
        reg_rd(RA_CSUM, v);   chk("R3 csum", v, exp_cs);
        for (int i = 0; i < 4; i++) chk("R3 fill", memrd(32'h2000 + 4*i), SEED + i);
        chk("R6 legacy kind", last_kind, 0);
        chk("R6 legacy vec", last_vec, 0);

        // R4 copy, MSI-X vector 2048 (upper bound)
        setup(32'h1000, 32'h3000, 6, 2, 2048);
        exp_cs = 0;
        for (int i = 0; i < 6; i++) exp_cs ^= memrd(32'h1000 + 4*i);
        run_cmd(32'h20, 1);
        reg_rd(RA_STATUS, v); chk("R4 status", v, 32'h050);
        reg_rd(RA_CSUM, v);   chk("R4 csum", v, exp_cs);
        for (int i = 0; i < 6; i++) chk("R4 copy data", memrd(32'h3000 + 4*i), memrd(32'h1000 + 4*i));
        chk("R6 msix kind", last_kind, 2);
        chk("R6 msix vec", last_vec, 2048);

        // R5 bad source on read
        setup(32'h0, 32'h2000, 3, 1, 4);
        run_cmd(32'h08, 1);
        reg_rd(RA_STATUS, v); chk("R5 read bad src", v, 32'h0C2);
        chk("R5 no access", acc_cnt, 0);

        // R5 bad source and destination on copy; R11 status cleared before
        setup(32'h1002, 32'h0, 3, 1, 4);
        run_cmd(32'h20, 1);
        reg_rd(RA_STATUS, v); chk("R5 R11 copy both bad", v, 32'h1E0);
        chk("R5 copy no access", acc_cnt, 0);

        // R11 success after failure shows only new result
        setup(32'h1000, 32'h2000, 1, 1, 4);
        run_cmd(32'h08, 1);
        reg_rd(RA_STATUS, v); chk("R11 cleared status", v, 32'h041);

        // R7 out-of-range numbers
        setup(32'h1000, 32'h2000, 2, 1, 33);
        run_cmd(32'h08, 0);
        reg_rd(RA_STATUS, v); chk("R7 msi 33 status", v, 32'h001);
        chk("R7 msi 33 no irq", irq_cnt, 0);
        setup(32'h1000, 32'h2000, 2, 2, 0);
        run_cmd(32'h08, 0);
        reg_rd(RA_STATUS, v); chk("R7 msix 0 status", v, 32'h001);
        chk("R7 msix 0 no irq", irq_cnt, 0);
        setup(32'h1000, 32'h2000, 2, 3, 1);
        run_cmd(32'h08, 0);
        chk("R7 kind 3 no irq", irq_cnt, 0);

        // R8 bare MSI interrupt with kind register at legacy
        setup(32'h1000, 32'h2000, 2, 0, 7);
        run_cmd(32'h02, 1);
        reg_rd(RA_STATUS, v); chk("R8 bare status", v, 32'h040);
        chk("R8 bare kind", last_kind, 1);
        chk("R8 bare vec", last_vec, 7);
        chk("R8 bare no access", acc_cnt, 0);

        // R9 read and write together: read wins
        setup(32'h1000, 32'h5000, 3, 1, 1);
        run_cmd(32'h18, 1);
        reg_rd(RA_STATUS, v); chk("R9 priority status", v, 32'h041);
        chk("R9 no write", {31'b0, mem.exists(32'h5000)}, 0);
        chk("R9 accesses", acc_cnt, 3);

        // R10 busy: second command ignored, bit held during run
        setup(32'h1000, 32'h4000, 20, 1, 5);
        irq_cnt = 0; acc_cnt = 0; irq_allow = 1'b1; in_cmd = 1'b1;
        reg_wr(RA_CMD, 32'h10);
        reg_wr(RA_CMD, 32'h20);
        reg_rd(RA_CMD, v); chk("R10 busy readback", v, 32'h10);
        wait_idle();
        reg_rd(RA_STATUS, v); chk("R10 status", v, 32'h044);
        chk("R10 accesses", acc_cnt, 20);
        chk("R10 fill kept", memrd(32'h4000 + 4*19), SEED + 19);
        chk("R10 single irq", irq_cnt, 1);
        reg_rd(RA_CMD, v); chk("R10 self clear", v, 0);

        // R3 size zero
        setup(32'h1000, 32'h6000, 0, 1, 2);
        run_cmd(32'h10, 1);
        reg_rd(RA_STATUS, v); chk("R3 size0 status", v, 32'h044);
        reg_rd(RA_CSUM, v);   chk("R3 size0 csum", v, 0);
        chk("R3 size0 no access", acc_cnt, 0);

        // R12 error response mid-read
        setup(32'h1000, 32'h2000, 2, 1, 1);
        exp_cs = memrd(32'h1000) ^ memrd(32'h1004);
        run_cmd(32'h08, 1);
        reg_rd(RA_CSUM, prev_cs); chk("R2 csum pre-error", prev_cs, exp_cs);
        err_addr = 32'h1008;
        setup(32'h1000, 32'h2000, 4, 1, 3);
        run_cmd(32'h08, 1);
        reg_rd(RA_STATUS, v); chk("R12 status", v, 32'h042);
        reg_rd(RA_CSUM, v);   chk("R12 csum kept", v, prev_cs);
        chk("R12 accesses", acc_cnt, 3);
        err_addr = 32'hFFFF_FFF0;

        // R2 maximum size read
        setup(32'h8000, 32'h2000, 255, 1, 32);
        exp_cs = 0;
        for (int i = 0; i < 255; i++) exp_cs ^= memrd(32'h8000 + 4*i);
        run_cmd(32'h08, 1);
        reg_rd(RA_CSUM, v); chk("R2 max csum", v, exp_cs);
        chk("R2 max accesses", acc_cnt, 255);
        chk("R7 msi 32 vec", last_vec, 32);

        finish_up();
    end

endmodule